// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches and jumps of a five-stage in-order pipeline while the control-transfer instruction sits in decode. It compares the two register operands for equality, builds the redirect address, and tells fetch to take that address. The same-cycle register path carries the result. The instruction that follows a branch or jump in program order has already been fetched when the decision is made. It always completes, because the block has no way to cancel it and never needs one. A taken decision therefore only changes which address fetch uses next, after that slot instruction.

Register values come from a register file that writes in the first half of a cycle and reads in the second half. A value being written back in the same cycle therefore already appears on the operand inputs. A result that an ALU instruction left in the memory stage is forwarded into the comparator. A result still being computed in execute, or a load still in the memory stage, holds the branch in decode. The block raises a stall request and makes the decision again on every following cycle until the operands are valid.

Top module: `brResolveTop`

## Requirements
- R1: Opcode encoding is 2'b00 no control transfer, 2'b01 branch-if-equal, 2'b10 branch-if-not-equal, 2'b11 jump. A branch-if-equal raises `pcSel` in the same cycle exactly when its two operands are bit-for-bit equal.
- R2: A branch-if-not-equal raises `pcSel` in the same cycle exactly when its two operands differ.
- R3: A jump always raises `pcSel` and never raises `stallReq`, whatever the hazard inputs show.
- R4: For a branch, `targetPc` equals `pcD` + 4 + (the low 16 bits of `immD`, sign-extended and shifted left by 2). Negative offsets reach backward.
- R5: For a jump, `targetPc` is the top 4 bits of `pcD` + 4, followed by all 26 bits of `immD`, followed by two zero bits.
- R6: A branch whose non-zero source index matches `exWrIdx` while `exWrEn` is high raises `stallReq` and keeps `pcSel` low. Once that hazard clears, the decision appears in the same cycle.
- R7: A branch whose non-zero source index matches `memWrIdx` while `memWrEn` and `memIsLoad` are both high raises `stallReq` and keeps `pcSel` low.
- R8: When `memWrEn` is high, `memIsLoad` is low and `memWrIdx` matches a non-zero source index, the comparator uses `memResult` in place of that register value.
- R9: Source index 0 never causes a stall and never takes a forwarded value.
- R10: With opcode 2'b00, `pcSel` and `stallReq` stay low for any operand and hazard inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rstN | input | 1 | Active-low reset, disables the embedded checks |
| opD | input | 2 | Decode-stage control-transfer opcode |
| rsIdx | input | 5 | First source register index |
| rtIdx | input | 5 | Second source register index |
| rsVal | input | 32 | First operand from the register file |
| rtVal | input | 32 | Second operand from the register file |
| immD | input | 26 | Jump index; its low 16 bits are the branch offset |
| pcD | input | 32 | Address of the instruction in decode |
| exWrEn | input | 1 | Execute-stage instruction writes a register |
| exWrIdx | input | 5 | Destination index of the execute-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| memWrIdx | input | 5 | Destination index of the memory-stage instruction |
| memResult | input | 32 | ALU result held in the memory stage |
| pcSel | output | 1 | Take `targetPc` as the next fetch address |
| targetPc | output | 32 | Branch or jump destination |
| stallReq | output | 1 | Hold decode and PC this cycle |

## Verification
Every result is due in the same cycle as its stimulus, because no register sits between any input and any output. Each check drives its inputs just after a falling edge and samples one time unit later, well before the next rising edge. For the stall-release case, the hazard is dropped at a later falling edge, and the redirect must appear in that same half cycle without waiting for a clock edge.

// File: rtl/brPkg.sv
package brPkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_BEQ  = 2'b01,
    OP_BNE  = 2'b10,
    OP_JMP  = 2'b11
  } brOp_e;

  typedef struct packed {
    logic fwdA;
    logic fwdB;
    logic selJump;
  } brStrobe_t;
endpackage

// File: rtl/brCtrl.sv
module brCtrl
  import brPkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opD,
  input  logic [RIDX_W-1:0] rsIdx,
  input  logic [RIDX_W-1:0] rtIdx,
  input  logic              exWrEn,
  input  logic [RIDX_W-1:0] exWrIdx,
  input  logic              memWrEn,
  input  logic              memIsLoad,
  input  logic [RIDX_W-1:0] memWrIdx,
  input  logic              eqFlag,
  output brStrobe_t         strobes,
  output logic              pcSel,
  output logic              stallReq
);
  localparam int NSRC = 2;

  brOp_e opK;
  logic isCond;
  logic [RIDX_W-1:0] srcIdx [NSRC];
  logic [NSRC-1:0] hzEx;
  logic [NSRC-1:0] hzLd;
  logic [NSRC-1:0] fwdMem;

  assign opK       = brOp_e'(opD);
  assign isCond    = (opK == OP_BEQ) || (opK == OP_BNE);
  assign srcIdx[0] = rsIdx;
  assign srcIdx[1] = rtIdx;

  for (genvar k = 0; k < NSRC; k++) begin : gSrc
    logic live;
    assign live      = isCond && (srcIdx[k] != '0);
    assign hzEx[k]   = live && exWrEn && (exWrIdx == srcIdx[k]);
    assign hzLd[k]   = live && memWrEn && memIsLoad && (memWrIdx == srcIdx[k]);
    assign fwdMem[k] = live && memWrEn && !memIsLoad && (memWrIdx == srcIdx[k]);
  end

  assign stallReq        = (|hzEx) || (|hzLd);
  assign strobes.fwdA    = fwdMem[0];
  assign strobes.fwdB    = fwdMem[1];
  assign strobes.selJump = (opK == OP_JMP);

  always_comb begin
    pcSel = 1'b0;
    unique case (opK)
      OP_JMP:  pcSel = 1'b1;
      OP_BEQ:  pcSel = !stallReq && eqFlag;
      OP_BNE:  pcSel = !stallReq && !eqFlag;
      default: pcSel = 1'b0;
    endcase
  end

  AST_STALL_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> !pcSel); // R6
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (opD == 2'b11) |-> (pcSel && !stallReq)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opD == 2'b00) |-> (!pcSel && !stallReq)); // R10
  AST_ZERO_NO_HAZARD: assert property (@(posedge clk) disable iff (!rstN)
    ((rsIdx == '0) && (rtIdx == '0)) |-> (!stallReq && !strobes.fwdA && !strobes.fwdB)); // R9
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobes,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [XLEN-1:0]   memResult,
  input  logic [JIDX_W-1:0] immD,
  input  logic [XLEN-1:0]   pcD,
  output logic              eqFlag,
  output logic [XLEN-1:0]   targetPc
);
  localparam int ALIGN_W = 2;
  localparam int SEXT_W  = XLEN - OFF_W - ALIGN_W;
  localparam int PCHI_W  = XLEN - JIDX_W - ALIGN_W;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(1 << ALIGN_W);

  logic [XLEN-1:0] regVal [2];
  logic [XLEN-1:0] opnd   [2];
  logic [1:0]      useFwd;
  logic [XLEN-1:0] bitEq;
  logic [XLEN-1:0] pcNext, brTarget, jTarget, offExt;

  assign regVal[0] = rsVal;
  assign regVal[1] = rtVal;
  assign useFwd    = {strobes.fwdB, strobes.fwdA};

  for (genvar k = 0; k < 2; k++) begin : gOpnd
    assign opnd[k] = useFwd[k] ? memResult : regVal[k];
  end

  for (genvar i = 0; i < XLEN; i++) begin : gXnor
    assign bitEq[i] = ~(opnd[0][i] ^ opnd[1][i]);
  end
  assign eqFlag = &bitEq;

  assign pcNext   = pcD + PC_STEP;
  assign offExt   = {{SEXT_W{immD[OFF_W-1]}}, immD[OFF_W-1:0], {ALIGN_W{1'b0}}};
  assign brTarget = pcNext + offExt;
  assign jTarget  = {pcNext[XLEN-1 -: PCHI_W], immD, {ALIGN_W{1'b0}}};
  assign targetPc = strobes.selJump ? jTarget : brTarget;

  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (opnd[0] == opnd[1]) == eqFlag); // R1
endmodule

// File: rtl/brResolveTop.sv
module brResolveTop
  import brPkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opD,
  input  logic [RIDX_W-1:0] rsIdx,
  input  logic [RIDX_W-1:0] rtIdx,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [JIDX_W-1:0] immD,
  input  logic [XLEN-1:0]   pcD,
  input  logic              exWrEn,
  input  logic [RIDX_W-1:0] exWrIdx,
  input  logic              memWrEn,
  input  logic              memIsLoad,
  input  logic [RIDX_W-1:0] memWrIdx,
  input  logic [XLEN-1:0]   memResult,
  output logic              pcSel,
  output logic [XLEN-1:0]   targetPc,
  output logic              stallReq
);
  brStrobe_t strobes;
  logic eqFlag;

  brCtrl #(.RIDX_W(RIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opD(opD), .rsIdx(rsIdx), .rtIdx(rtIdx),
    .exWrEn(exWrEn), .exWrIdx(exWrIdx), .memWrEn(memWrEn),
    .memIsLoad(memIsLoad), .memWrIdx(memWrIdx), .eqFlag(eqFlag),
    .strobes(strobes), .pcSel(pcSel), .stallReq(stallReq)
  );

  brDatapath #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rsVal(rsVal), .rtVal(rtVal),
    .memResult(memResult), .immD(immD), .pcD(pcD), .eqFlag(eqFlag),
    .targetPc(targetPc)
  );
endmodule

// File: tb/brResolveTop_tb.sv
`timescale 1ns/1ps
module brResolveTop_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opD;
  logic [4:0] rsIdx, rtIdx, exWrIdx, memWrIdx;
  logic [31:0] rsVal, rtVal, pcD, memResult, targetPc;
  logic [25:0] immD;
  logic exWrEn, memWrEn, memIsLoad, pcSel, stallReq;
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brResolveTop u_dut (
    .clk(clk), .rstN(rstN), .opD(opD), .rsIdx(rsIdx), .rtIdx(rtIdx),
    .rsVal(rsVal), .rtVal(rtVal), .immD(immD), .pcD(pcD), .exWrEn(exWrEn),
    .exWrIdx(exWrIdx), .memWrEn(memWrEn), .memIsLoad(memIsLoad),
    .memWrIdx(memWrIdx), .memResult(memResult), .pcSel(pcSel),
    .targetPc(targetPc), .stallReq(stallReq)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [31:0] rsV;
    logic [31:0] rtV;
    logic [25:0] imm;
    logic [31:0] pc;
    logic        exEn;
    logic [4:0]  exIdx;
    logic        memEn;
    logic        memLd;
    logic [4:0]  memIdx;
    logic [31:0] memRes;
    logic        expSel;
    logic        expStall;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 5'd1, 5'd2, 32'd5, 32'd5, 26'h0004, 32'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 8'd1},
    '{2'b01, 5'd1, 5'd2, 32'd5, 32'd6, 26'h0004, 32'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 8'd1},
    '{2'b10, 5'd1, 5'd2, 32'd5, 32'd6, 26'hFFFC, 32'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 8'd4},
    '{2'b10, 5'd1, 5'd2, 32'd7, 32'd7, 26'hFFFC, 32'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 8'd2},
    '{2'b11, 5'd0, 5'd0, 32'd1, 32'd2, 26'h0000040, 32'hA000_1000, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 8'd5},
    '{2'b01, 5'd3, 5'd2, 32'd8, 32'd8, 26'h0010, 32'h2000, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 8'd6},
    '{2'b01, 5'd1, 5'd4, 32'd8, 32'd8, 26'h0010, 32'h2000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd4, 32'd0, 1'b0, 1'b1, 8'd7},
    '{2'b01, 5'd7, 5'd2, 32'd1, 32'd9, 26'h0020, 32'h3000, 1'b0, 5'd0, 1'b1, 1'b0, 5'd7, 32'd9, 1'b1, 1'b0, 8'd8},
    '{2'b10, 5'd2, 5'd7, 32'd4, 32'd0, 26'h0020, 32'h3000, 1'b0, 5'd0, 1'b1, 1'b0, 5'd7, 32'd4, 1'b0, 1'b0, 8'd8},
    '{2'b01, 5'd0, 5'd0, 32'd0, 32'd0, 26'h0008, 32'h4000, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 32'd5, 1'b1, 1'b0, 8'd9},
    '{2'b00, 5'd3, 5'd3, 32'd1, 32'd1, 26'h0008, 32'h4000, 1'b1, 5'd3, 1'b1, 1'b1, 5'd3, 32'd0, 1'b0, 1'b0, 8'd10},
    '{2'b11, 5'd3, 5'd3, 32'd1, 32'd2, 26'h3FFFFFF, 32'h5000_0000, 1'b1, 5'd3, 1'b1, 1'b1, 5'd3, 32'd0, 1'b1, 1'b0, 8'd3}
  };

  function automatic logic [31:0] refTarget(input logic [1:0] op, input logic [31:0] pc,
                                            input logic [25:0] imm);
    logic [31:0] nxt;
    nxt = pc + 32'd4;
    if (op == 2'b11) return {nxt[31:28], imm, 2'b00};
    return nxt + {{14{imm[15]}}, imm[15:0], 2'b00};
  endfunction

  task automatic check1(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    opD = v.op; rsIdx = v.rs; rtIdx = v.rt; rsVal = v.rsV; rtVal = v.rtV;
    immD = v.imm; pcD = v.pc; exWrEn = v.exEn; exWrIdx = v.exIdx;
    memWrEn = v.memEn; memIsLoad = v.memLd; memWrIdx = v.memIdx; memResult = v.memRes;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    applyVec('0);
    repeat (3) @(negedge clk);
    #1;
    check1("R10", "pcSel in reset", {31'd0, pcSel}, 32'd0);
    check1("R10", "stallReq in reset", {31'd0, stallReq}, 32'd0);
    rstN = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      applyVec(VECS[i]);
      #1;
      tag = $sformatf("R%0d", VECS[i].req);
      check1(tag, $sformatf("vec%0d pcSel", i), {31'd0, pcSel}, {31'd0, VECS[i].expSel});
      check1(tag, $sformatf("vec%0d stallReq", i), {31'd0, stallReq}, {31'd0, VECS[i].expStall});
      if (VECS[i].expSel) begin
        check1((VECS[i].op == 2'b11) ? "R5" : "R4", $sformatf("vec%0d targetPc", i),
               targetPc, refTarget(VECS[i].op, VECS[i].pc, VECS[i].imm));
      end
    end

    // R6: stall held, then released without a clock edge in between
    @(negedge clk);
    applyVec(VECS[5]);
    #1;
    check1("R6", "stalled pcSel", {31'd0, pcSel}, 32'd0);
    @(posedge clk);
    #1;
    check1("R6", "still stalled", {31'd0, stallReq}, 32'd1);
    @(negedge clk);
    exWrEn = 1'b0;
    #1;
    check1("R6", "released stallReq", {31'd0, stallReq}, 32'd0);
    check1("R6", "released pcSel", {31'd0, pcSel}, 32'd1);
    check1("R4", "released target", targetPc, refTarget(2'b01, 32'h2000, 26'h0010));

    // R4: most negative offset
    @(negedge clk);
    opD = 2'b10; rsIdx = 5'd1; rtIdx = 5'd2; rsVal = 32'd1; rtVal = 32'd2;
    immD = 26'h0008000; pcD = 32'h0004_0000; exWrEn = 1'b0; memWrEn = 1'b0;
    #1;
    check1("R4", "min offset target", targetPc, 32'h0002_0004);
    check1("R2", "min offset pcSel", {31'd0, pcSel}, 32'd1);

    // R9: index 0 on both sides ignores a non-load memory result
    @(negedge clk);
    opD = 2'b10; rsIdx = 5'd0; rtIdx = 5'd0; rsVal = 32'd0; rtVal = 32'd0;
    memWrEn = 1'b1; memIsLoad = 1'b0; memWrIdx = 5'd0; memResult = 32'hFFFF_FFFF;
    #1;
    check1("R9", "no forward for index 0", {31'd0, pcSel}, 32'd0);

    // R7: load in memory stage on the first source
    @(negedge clk);
    opD = 2'b10; rsIdx = 5'd9; rtIdx = 5'd2; rsVal = 32'd1; rtVal = 32'd2;
    memWrEn = 1'b1; memIsLoad = 1'b1; memWrIdx = 5'd9;
    #1;
    check1("R7", "load hazard stall", {31'd0, stallReq}, 32'd1);
    check1("R7", "load hazard pcSel", {31'd0, pcSel}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule